// File: doc/BRIEF.md
# Parallel DAC Write-Cycle Controller

The block accepts sample words from an upstream valid/ready stream and turns each one into a write cycle on a parallel converter port. The port has a data bus, an active-low chip select and an active-low write strobe. Every interval of the cycle is counted in system-clock cycles and derived from nanosecond minimums. The minimums covered are data setup and hold, select setup, strobe width and output settling.

The converter's input latch is modelled at the output so that a bench can observe the captured code. The latch passes data through while both strobes are low and holds it otherwise. In bipolar mode, a signed two's-complement sample is turned into offset binary by flipping its top bit. Zero then drives mid-scale, code 0x80.

Each transfer runs as follows. The bus is driven first. One cycle later select and strobe fall together and stay low for a computed window. They rise together again. Ready stays low until the settling interval after that rising edge has elapsed.

Top module: `dac_wr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, select and strobe are high and ready is high. The bus holds 0x00 with bipolar mode off and 0x80 with it on.
- R2: A sample is accepted on a clock edge where valid and ready are both high. Ready is low from the next cycle on.
- R3: The bus carries the new code in the cycle after acceptance, while select and strobe are still high. This gives one cycle of data lead before select falls.
- R4: Select and strobe fall in the same cycle and stay low for exactly LOW_CYC cycles. LOW_CYC is the largest of ceil(40 ns/T), ceil(25 ns/T) and one, and equals 5 at T = 8 ns.
- R5: Select and strobe rise in the same cycle, which gives zero select hold, and neither is ever low without the other.
- R6: The bus does not change from the cycle after acceptance until the next acceptance. This covers the whole low window and the data hold after the strobe rises.
- R7: Ready returns high exactly POST_CYC cycles after the strobe rises. POST_CYC is the larger of ceil(100 ns/T) and ceil(10 ns/T), and equals 13 at T = 8 ns. One transfer therefore takes LOW_CYC + POST_CYC + 2 cycles from acceptance to the next acceptance.
- R8: With bipolar mode off the bus equals the sample. With it on, bit 7 of the sample is inverted, so 0x00 maps to 0x80, 0x7F to 0xFF and 0x80 to 0x00.
- R9: The latch model output equals the bus while select and strobe are both low. Otherwise it holds the code last seen in that state, which is 0x00 after reset.
- R10: Valid and data presented while ready is low are ignored. They change neither the bus nor the latch model output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bipolar_i | input | 1 | Offset-binary mode select, held static |
| s_valid_i | input | 1 | Upstream sample valid |
| s_data_i | input | DATA_W | Upstream sample |
| s_ready_o | output | 1 | Controller can take a sample |
| dac_data_o | output | DATA_W | Converter data bus |
| dac_cs_no | output | 1 | Converter chip select, active low |
| dac_wr_no | output | 1 | Converter write strobe, active low |
| dac_latch_o | output | DATA_W | Model of the converter input latch contents |

## Verification
The properties assume that the mode input is a strap. It is set during reset and never changes while transfers run, because it feeds the bus directly. The stimulus changes it only with reset held. Upstream valid may be held, dropped or toggled freely, and data may change while the controller is busy. The bench does both on purpose to show that nothing leaks onto the bus. All inputs are driven just after the falling clock edge, so no input changes near the sampling edge.

// File: rtl/dac_wr_pkg.sv
package dac_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_POST
  } wr_state_e;

  // ceiling of ns / period, at least one cycle for a nonzero interval
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    if (ns == 0) return 0;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_code_map.sv
module dac_code_map #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              bipolar_i,
  output logic [DATA_W-1:0] code_o
);

  generate
    if (DATA_W > 1) begin : g_wide
      assign code_o = {raw_i[DATA_W-1] ^ bipolar_i, raw_i[DATA_W-2:0]};
    end else begin : g_bit
      assign code_o = raw_i ^ bipolar_i;
    end
  endgenerate

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOW_CYC  = 5,
  parameter int unsigned POST_CYC = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] raw_o,
  output logic              cs_no,
  output logic              wr_no
);

  localparam int unsigned MAX_CNT = (LOW_CYC > POST_CYC) ? LOW_CYC : POST_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  wr_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] raw_q;
  logic              cs_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      raw_q   <= '0;
      cs_q    <= 1'b1;
      wr_q    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (valid_i) begin
            raw_q   <= data_i;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          cs_q    <= 1'b0;
          wr_q    <= 1'b0;
          cnt_q   <= CNT_W'(LOW_CYC - 1);
          state_q <= ST_LOW;
        end
        ST_LOW: begin
          if (cnt_q == '0) begin
            cs_q    <= 1'b1;
            wr_q    <= 1'b1;
            cnt_q   <= CNT_W'(POST_CYC - 1);
            state_q <= ST_POST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_POST: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign raw_o   = raw_q;
  assign cs_no   = cs_q;
  assign wr_no   = wr_q;

endmodule

// File: rtl/dac_in_latch.sv
module dac_in_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);

  logic              open_w;
  logic [DATA_W-1:0] held_q;

  assign open_w = ~cs_ni & ~wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= '0;
    else if (open_w) held_q <= d_i;
  end

  assign q_o = open_w ? d_i : held_q;

endmodule

// File: rtl/dac_wr_ctrl.sv
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned CS_SETUP_NS   = 40,
  parameter int unsigned D_SETUP_NS    = 25,
  parameter int unsigned D_HOLD_NS     = 10,
  parameter int unsigned WR_WIDTH_NS   = 40,
  parameter int unsigned SETTLE_NS     = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bipolar_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic [DATA_W-1:0] dac_data_o,
  output logic              dac_cs_no,
  output logic              dac_wr_no,
  output logic [DATA_W-1:0] dac_latch_o
);

  // low window must cover select setup, data setup and strobe width
  localparam int unsigned LOW_CYC = max2(max2(ns_to_cyc(CS_SETUP_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(D_SETUP_NS, CLK_PERIOD_NS)),
                                         max2(ns_to_cyc(WR_WIDTH_NS, CLK_PERIOD_NS), 1));
  // post window covers data hold and output settling
  localparam int unsigned POST_CYC = max2(max2(ns_to_cyc(SETTLE_NS, CLK_PERIOD_NS),
                                               ns_to_cyc(D_HOLD_NS, CLK_PERIOD_NS)), 1);

  logic [DATA_W-1:0] raw_w;

  dac_wr_seq #(
    .DATA_W  (DATA_W),
    .LOW_CYC (LOW_CYC),
    .POST_CYC(POST_CYC)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(s_valid_i),
    .data_i (s_data_i),
    .ready_o(s_ready_o),
    .raw_o  (raw_w),
    .cs_no  (dac_cs_no),
    .wr_no  (dac_wr_no)
  );

  dac_code_map #(.DATA_W(DATA_W)) u_map (
    .raw_i    (raw_w),
    .bipolar_i(bipolar_i),
    .code_o   (dac_data_o)
  );

  dac_in_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (dac_cs_no),
    .wr_ni (dac_wr_no),
    .d_i   (dac_data_o),
    .q_o   (dac_latch_o)
  );

endmodule

// File: rtl/dac_wr_chk.sv
module dac_wr_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned LOW_CYC = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic [DATA_W-1:0] dac_data_o,
  input logic              dac_cs_no,
  input logic              dac_wr_no,
  input logic [DATA_W-1:0] dac_latch_o
);

  logic [15:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        low_cnt_q <= '0;
    else if (dac_wr_no) low_cnt_q <= '0;
    else                low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_idle_strobes_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (dac_cs_no && dac_wr_no));

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> !s_ready_o);

  assert_data_leads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> (dac_cs_no && dac_wr_no));

  assert_low_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_wr_no) |-> (low_cnt_q == 16'(LOW_CYC)));

  assert_strobes_paired_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_cs_no == dac_wr_no);

  assert_bus_stable_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_cs_no || $rose(dac_wr_no)) |-> $stable(dac_data_o));

  assert_latch_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_cs_no && !dac_wr_no) |-> (dac_latch_o == dac_data_o));

  assert_busy_ignores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ready_o |=> $stable(dac_data_o));

endmodule

bind dac_wr_ctrl dac_wr_chk #(
  .DATA_W (DATA_W),
  .LOW_CYC(LOW_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_valid_i  (s_valid_i),
  .s_ready_o  (s_ready_o),
  .dac_data_o (dac_data_o),
  .dac_cs_no  (dac_cs_no),
  .dac_wr_no  (dac_wr_no),
  .dac_latch_o(dac_latch_o)
);

// File: tb/tb_dac_wr_ctrl.sv
module tb_dac_wr_ctrl;

  localparam int CLK_NS = 8;

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int LOW_N  = (cdiv(40) > cdiv(25)) ? cdiv(40) : cdiv(25);
  localparam int POST_N = (cdiv(100) > cdiv(10)) ? cdiv(100) : cdiv(10);
  localparam int LAST_T = LOW_N + POST_N + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bipolar = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_ready;
  logic [7:0] dac_data, dac_latch;
  logic       cs_n, wr_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  dac_wr_ctrl #(.CLK_PERIOD_NS(CLK_NS)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bipolar_i  (bipolar),
    .s_valid_i  (s_valid),
    .s_data_i   (s_data),
    .s_ready_o  (s_ready),
    .dac_data_o (dac_data),
    .dac_cs_no  (cs_n),
    .dac_wr_no  (wr_n),
    .dac_latch_o(dac_latch)
  );

  function automatic int code_of(input int raw);
    return bipolar ? (raw ^ 8'h80) : raw;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // reference model: m_t counts cycles since acceptance, 0 = idle
  int m_t = 0, m_raw = 0, m_lat = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_raw = 0; m_lat = 0;
    end else if (m_t == 0) begin
      if (s_valid) begin m_t = 1; m_raw = s_data; end
    end else if (m_t == LAST_T) begin
      m_t = 0;
    end else begin
      m_t++;
      if (m_t == 2) m_lat = code_of(m_raw);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit low = (m_t >= 2) && (m_t <= LOW_N + 1);
      chk("R2 R7 ready", s_ready, m_t == 0);
      chk("R3 R4 cs", cs_n, !low);
      chk("R4 R5 wr", wr_n, !low);
      chk("R6 R8 R10 bus", dac_data, code_of(m_raw));
      chk("R9 R10 latch", dac_latch, low ? code_of(m_raw) : m_lat);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // junk: keep valid high with other data while busy (R10)
  task automatic send(input logic [7:0] d, input bit junk);
    s_valid = 1'b1; s_data = d;
    do tick(); while (m_t != 1);
    s_valid = junk; s_data = ~d;
    while (m_t != LAST_T) begin
      tick();
      if (junk) s_data = s_data + 8'h13;
    end
    s_valid = 1'b0;
  endtask

  task automatic do_reset(input bit bip);
    rst_n = 1'b0; bipolar = bip; s_valid = 1'b0;
    repeat (3) tick();
    chk("R1 reset cs", cs_n, 1);
    chk("R1 reset wr", wr_n, 1);
    chk("R1 reset ready", s_ready, 1);
    chk("R1 reset bus", dac_data, bip ? 8'h80 : 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R1 post reset bus", dac_data, bip ? 8'h80 : 8'h00);
    chk("R9 post reset latch", dac_latch, 8'h00);
  endtask

  initial begin
    do_reset(1'b0);
    send(8'h5A, 1'b0);
    send(8'hFF, 1'b1);
    send(8'h00, 1'b0);
    send(8'h81, 1'b1);
    repeat (4) tick();
    send(8'h7E, 1'b0);
    do_reset(1'b1);
    send(8'h00, 1'b0);
    send(8'h7F, 1'b1);
    send(8'h80, 1'b0);
    send(8'hC3, 1'b1);
    repeat (30) tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule